// File: doc/BRIEF.md
# Screen Tile Binner

The block sorts a stream of screen-space triangles into per-tile lists so that a later pixel stage can work through the screen one 16x16-pixel tile at a time. Each triangle arrives with an index and an axis-aligned bounding box in pixel coordinates. The binner clamps the box to the screen and works out the rectangle of tiles it touches. It then writes the triangle index into the list of every tile in that rectangle, one tile per clock. The lists are held in on-chip registers.

A pass has two phases. A start pulse clears every list and opens the binning phase. Triangles are then accepted through a valid/ready handshake until an end pulse arrives. Once the last accepted triangle has been fully binned, the readout phase replays the tiles in row-major order, one beat per cycle. Each tile sends its indices in the order they were submitted, followed by a marker beat that carries the tile's entry count and its overflow flag. A list never holds more than its fixed capacity. Any further append to a full list is dropped, and the drop raises a per-tile flag and a sticky global flag.

Top module: `tile_binner`

## Requirements
- R1: After reset, tri_ready_o, out_valid_o and ovf_o are low and the block is idle.
- R2: A pass_start_i pulse while idle clears all tile counts, per-tile flags and ovf_o. It raises tri_ready_o on the next clock.
- R3: An accepted triangle is appended to every tile whose column lies in [x0/16, min(x1,SCREEN_W-1)/16] and whose row lies in [y0/16, min(y1,SCREEN_H-1)/16]. The tile number is row*TILES_X+column. With defaults TILES_X=8, TILES_Y=4 and 32 tiles.
- R4: A triangle with x0>=SCREEN_W, y0>=SCREEN_H, x1<x0 or y1<y0 is discarded and appends to no tile.
- R5: Within each tile the indices are replayed in the order the triangles were accepted.
- R6: Each list holds at most LIST_DEPTH (default 4) indices. An append to a full list is dropped and sets that tile's overflow flag.
- R7: Readout goes through tiles 0 to NUM_TILES-1 with one beat per cycle and no gaps. For each tile, out_eot_o=0 beats carry the indices. These are followed by one out_eot_o=1 beat that carries out_count_o (entries kept) and out_tile_ovf_o. out_valid_o falls after the last tile's marker.
- R8: After pass_end_i, tri_ready_o stays low. Readout starts only after every accepted triangle is binned, and a triangle accepted in the same cycle as pass_end_i is included.
- R9: pass_start_i during binning or readout is ignored: lists are neither cleared nor restarted.
- R10: ovf_o is sticky from the first dropped append until the next accepted pass_start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pass_start_i | input | 1 | Opens a new pass when idle |
| pass_end_i | input | 1 | Closes binning; readout follows |
| tri_valid_i | input | 1 | Triangle offered |
| tri_ready_o | output | 1 | Triangle accepted on this edge when valid |
| tri_idx_i | input | IDX_W | Triangle index |
| tri_x0_i | input | COORD_W | Bounding box left |
| tri_y0_i | input | COORD_W | Bounding box top |
| tri_x1_i | input | COORD_W | Bounding box right (inclusive) |
| tri_y1_i | input | COORD_W | Bounding box bottom (inclusive) |
| out_valid_o | output | 1 | Readout beat valid |
| out_eot_o | output | 1 | Beat is the end-of-tile marker |
| out_tile_o | output | TILE_W | Tile number of the beat |
| out_idx_o | output | IDX_W | Triangle index (index beats) |
| out_count_o | output | CNT_W | Entries kept (marker beats) |
| out_tile_ovf_o | output | 1 | Tile dropped an append (marker beats) |
| ovf_o | output | 1 | Sticky overflow for the pass |

## Verification
Two events can land in the same clock edge. The first is the acceptance of a triangle on the handshake. The second is the pass_end_i that closes binning. The bench raises pass_end_i together with the last triangle of a pass, at the point where tri_ready_o is already high. It then checks that this triangle's index appears in the replayed lists of all tiles it covers. A late start of readout, or a dropped final triangle, therefore shows up as a mismatch in the replayed lists.

// File: rtl/tile_binner_pkg.sv
package tile_binner_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIN  = 2'd1,
    ST_READ = 2'd2
  } bin_state_e;
endpackage

// File: rtl/tbn_range.sv
module tbn_range #(
  parameter int SCREEN_W  = 128,
  parameter int SCREEN_H  = 64,
  parameter int TILE_LOG2 = 4,
  parameter int COORD_W   = 10,
  parameter int TX_W      = 3,
  parameter int TY_W      = 2
) (
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  output logic [TX_W-1:0]    tx0_o,
  output logic [TX_W-1:0]    tx1_o,
  output logic [TY_W-1:0]    ty0_o,
  output logic [TY_W-1:0]    ty1_o,
  output logic               keep_o
);
  localparam logic [COORD_W-1:0] X_MAX = COORD_W'(SCREEN_W - 1);
  localparam logic [COORD_W-1:0] Y_MAX = COORD_W'(SCREEN_H - 1);

  logic [COORD_W-1:0] x1_c, y1_c;

  always_comb begin
    x1_c   = (x1_i > X_MAX) ? X_MAX : x1_i;
    y1_c   = (y1_i > Y_MAX) ? Y_MAX : y1_i;
    keep_o = (x0_i <= X_MAX) && (y0_i <= Y_MAX) && (x1_i >= x0_i) && (y1_i >= y0_i);
    tx0_o  = TX_W'(x0_i >> TILE_LOG2);
    tx1_o  = TX_W'(x1_c >> TILE_LOG2);
    ty0_o  = TY_W'(y0_i >> TILE_LOG2);
    ty1_o  = TY_W'(y1_c >> TILE_LOG2);
  end
endmodule

// File: rtl/tbn_walker.sv
module tbn_walker #(
  parameter int TILES_X = 8,
  parameter int TX_W    = 3,
  parameter int TY_W    = 2,
  parameter int TILE_W  = 5,
  parameter int IDX_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TX_W-1:0]   tx0_i,
  input  logic [TX_W-1:0]   tx1_i,
  input  logic [TY_W-1:0]   ty0_i,
  input  logic [TY_W-1:0]   ty1_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [TILE_W-1:0] wr_tile_o,
  output logic [IDX_W-1:0]  wr_idx_o
);
  logic              busy_q;
  logic [TX_W-1:0]   tx_q, tx0_q, tx1_q;
  logic [TY_W-1:0]   ty_q, ty1_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tx_q   <= '0;
      tx0_q  <= '0;
      tx1_q  <= '0;
      ty_q   <= '0;
      ty1_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tx_q   <= tx0_i;
      tx0_q  <= tx0_i;
      tx1_q  <= tx1_i;
      ty_q   <= ty0_i;
      ty1_q  <= ty1_i;
      idx_q  <= idx_i;
    end else if (busy_q) begin
      if (tx_q == tx1_q) begin
        tx_q <= tx0_q;
        if (ty_q == ty1_q) busy_q <= 1'b0;
        else               ty_q   <= ty_q + TY_W'(1);
      end else begin
        tx_q <= tx_q + TX_W'(1);
      end
    end
  end

  // row-major tile number
  assign wr_tile_o = TILE_W'(int'(ty_q) * TILES_X + int'(tx_q));
  assign wr_en_o   = busy_q;
  assign wr_idx_o  = idx_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/tbn_store.sv
module tbn_store #(
  parameter int NUM_TILES  = 32,
  parameter int LIST_DEPTH = 4,
  parameter int TILE_W     = 5,
  parameter int CNT_W      = 3,
  parameter int IDX_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [TILE_W-1:0] wr_tile_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TILE_W-1:0] rd_tile_i,
  input  logic [CNT_W-1:0]  rd_pos_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              rd_tovf_o,
  output logic              ovf_o
);
  localparam int ENTRIES = NUM_TILES * LIST_DEPTH;
  localparam int ADDR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LIST_DEPTH);

  logic [IDX_W-1:0]     mem_q [ENTRIES];
  logic [CNT_W-1:0]     cnt_q [NUM_TILES];
  logic [NUM_TILES-1:0] tovf_q;
  logic                 ovf_q;
  logic [CNT_W-1:0]     wr_cnt;
  logic                 wr_room;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;

  always_comb begin
    wr_cnt  = cnt_q[wr_tile_i];
    wr_room = (wr_cnt < FULL);
    wr_addr = ADDR_W'(int'(wr_tile_i) * LIST_DEPTH + int'(wr_cnt));
    rd_addr = ADDR_W'(int'(rd_tile_i) * LIST_DEPTH + int'(rd_pos_i));
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_room && !clear_i) mem_q[wr_addr] <= wr_idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_TILES; t++) cnt_q[t] <= '0;
      tovf_q <= '0;
      ovf_q  <= 1'b0;
    end else if (clear_i) begin
      for (int t = 0; t < NUM_TILES; t++) cnt_q[t] <= '0;
      tovf_q <= '0;
      ovf_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_room) begin
        cnt_q[wr_tile_i] <= wr_cnt + CNT_W'(1);
      end else begin
        tovf_q[wr_tile_i] <= 1'b1;
        ovf_q             <= 1'b1;
      end
    end
  end

  assign rd_idx_o  = mem_q[rd_addr];
  assign rd_cnt_o  = cnt_q[rd_tile_i];
  assign rd_tovf_o = tovf_q[rd_tile_i];
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/tbn_readout.sv
module tbn_readout #(
  parameter int NUM_TILES = 32,
  parameter int TILE_W    = 5,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              tovf_i,
  output logic [TILE_W-1:0] rd_tile_o,
  output logic [CNT_W-1:0]  rd_pos_o,
  output logic              done_o,
  output logic              out_valid_o,
  output logic              out_eot_o,
  output logic [TILE_W-1:0] out_tile_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic [CNT_W-1:0]  out_count_o,
  output logic              out_tile_ovf_o
);
  localparam logic [TILE_W-1:0] LAST = TILE_W'(NUM_TILES - 1);

  logic              active_q;
  logic [TILE_W-1:0] tile_q;
  logic [CNT_W-1:0]  pos_q;
  logic              mark;

  assign mark   = (pos_q >= cnt_i);
  assign done_o = active_q && mark && (tile_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tile_q   <= '0;
      pos_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      tile_q   <= '0;
      pos_q    <= '0;
    end else if (active_q) begin
      if (mark) begin
        pos_q <= '0;
        if (tile_q == LAST) active_q <= 1'b0;
        else                tile_q   <= tile_q + TILE_W'(1);
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o    <= 1'b0;
      out_eot_o      <= 1'b0;
      out_tile_o     <= '0;
      out_idx_o      <= '0;
      out_count_o    <= '0;
      out_tile_ovf_o <= 1'b0;
    end else begin
      out_valid_o    <= active_q;
      out_eot_o      <= active_q && mark;
      out_tile_o     <= active_q ? tile_q : '0;
      out_idx_o      <= (active_q && !mark) ? idx_i : '0;
      out_count_o    <= (active_q && mark) ? cnt_i : '0;
      out_tile_ovf_o <= active_q && mark && tovf_i;
    end
  end

  assign rd_tile_o = tile_q;
  assign rd_pos_o  = pos_q;
endmodule

// File: rtl/tile_binner.sv
module tile_binner
  import tile_binner_pkg::*;
#(
  parameter int  SCREEN_W   = 128,
  parameter int  SCREEN_H   = 64,
  parameter int  TILE_LOG2  = 4,
  parameter int  LIST_DEPTH = 4,
  parameter int  IDX_W      = 8,
  parameter int  COORD_W    = 10,
  localparam int TILE_PIX   = 1 << TILE_LOG2,
  localparam int TILES_X    = (SCREEN_W + TILE_PIX - 1) / TILE_PIX,
  localparam int TILES_Y    = (SCREEN_H + TILE_PIX - 1) / TILE_PIX,
  localparam int NUM_TILES  = TILES_X * TILES_Y,
  localparam int TILE_W     = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
  localparam int TX_W       = (TILES_X > 1) ? $clog2(TILES_X) : 1,
  localparam int TY_W       = (TILES_Y > 1) ? $clog2(TILES_Y) : 1,
  localparam int CNT_W      = $clog2(LIST_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pass_start_i,
  input  logic               pass_end_i,
  input  logic               tri_valid_i,
  output logic               tri_ready_o,
  input  logic [IDX_W-1:0]   tri_idx_i,
  input  logic [COORD_W-1:0] tri_x0_i,
  input  logic [COORD_W-1:0] tri_y0_i,
  input  logic [COORD_W-1:0] tri_x1_i,
  input  logic [COORD_W-1:0] tri_y1_i,
  output logic               out_valid_o,
  output logic               out_eot_o,
  output logic [TILE_W-1:0]  out_tile_o,
  output logic [IDX_W-1:0]   out_idx_o,
  output logic [CNT_W-1:0]   out_count_o,
  output logic               out_tile_ovf_o,
  output logic               ovf_o
);
  bin_state_e        st_q;
  logic              end_pend_q;
  logic              idle_w, clear_w, accept_w, go_w;
  logic              keep_w, walk_busy, wr_en;
  logic [TX_W-1:0]   tx0, tx1;
  logic [TY_W-1:0]   ty0, ty1;
  logic [TILE_W-1:0] wr_tile, rd_tile;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [CNT_W-1:0]  rd_pos, rd_cnt;
  logic              rd_tovf, rd_done;

  assign idle_w      = (st_q == ST_IDLE);
  assign clear_w     = idle_w && pass_start_i;
  assign tri_ready_o = (st_q == ST_BIN) && !walk_busy && !end_pend_q;
  assign accept_w    = tri_valid_i && tri_ready_o;
  assign go_w        = (st_q == ST_BIN) && end_pend_q && !walk_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      end_pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pass_start_i) st_q <= ST_BIN;
        ST_BIN: begin
          if (go_w) begin
            st_q       <= ST_READ;
            end_pend_q <= 1'b0;
          end else if (pass_end_i) begin
            end_pend_q <= 1'b1;
          end
        end
        ST_READ: if (rd_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  tbn_range #(
    .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H), .TILE_LOG2(TILE_LOG2),
    .COORD_W(COORD_W), .TX_W(TX_W), .TY_W(TY_W)
  ) range_i (
    .x0_i(tri_x0_i), .y0_i(tri_y0_i), .x1_i(tri_x1_i), .y1_i(tri_y1_i),
    .tx0_o(tx0), .tx1_o(tx1), .ty0_o(ty0), .ty1_o(ty1), .keep_o(keep_w)
  );

  tbn_walker #(
    .TILES_X(TILES_X), .TX_W(TX_W), .TY_W(TY_W), .TILE_W(TILE_W), .IDX_W(IDX_W)
  ) walker_i (
    .clk_i, .rst_ni,
    .start_i(accept_w && keep_w), .idx_i(tri_idx_i),
    .tx0_i(tx0), .tx1_i(tx1), .ty0_i(ty0), .ty1_i(ty1),
    .busy_o(walk_busy), .wr_en_o(wr_en), .wr_tile_o(wr_tile), .wr_idx_o(wr_idx)
  );

  tbn_store #(
    .NUM_TILES(NUM_TILES), .LIST_DEPTH(LIST_DEPTH), .TILE_W(TILE_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) store_i (
    .clk_i, .rst_ni,
    .clear_i(clear_w), .wr_en_i(wr_en), .wr_tile_i(wr_tile), .wr_idx_i(wr_idx),
    .rd_tile_i(rd_tile), .rd_pos_i(rd_pos), .rd_idx_o(rd_idx),
    .rd_cnt_o(rd_cnt), .rd_tovf_o(rd_tovf), .ovf_o(ovf_o)
  );

  tbn_readout #(
    .NUM_TILES(NUM_TILES), .TILE_W(TILE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) readout_i (
    .clk_i, .rst_ni,
    .go_i(go_w), .idx_i(rd_idx), .cnt_i(rd_cnt), .tovf_i(rd_tovf),
    .rd_tile_o(rd_tile), .rd_pos_o(rd_pos), .done_o(rd_done),
    .out_valid_o, .out_eot_o, .out_tile_o, .out_idx_o, .out_count_o, .out_tile_ovf_o
  );
endmodule

// File: rtl/tile_binner_chk.sv
module tile_binner_chk #(
  parameter int NUM_TILES  = 32,
  parameter int LIST_DEPTH = 4,
  parameter int TILE_W     = 5,
  parameter int CNT_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pass_start_i,
  input logic              idle_i,
  input logic              tri_ready_o,
  input logic              out_valid_o,
  input logic              out_eot_o,
  input logic [TILE_W-1:0] out_tile_o,
  input logic [CNT_W-1:0]  out_count_o,
  input logic              ovf_o
);
  localparam logic [TILE_W-1:0] LAST = TILE_W'(NUM_TILES - 1);

  // R8
  bin_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !tri_ready_o);

  // R7
  tile_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eot_o && out_tile_o != LAST) |=>
      (out_valid_o && out_tile_o == $past(out_tile_o) + TILE_W'(1)));

  // R5
  tile_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_eot_o) |=> (out_valid_o && out_tile_o == $past(out_tile_o)));

  // R7
  read_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eot_o && out_tile_o == LAST) |=> !out_valid_o);

  // R6
  list_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eot_o) |-> (out_count_o <= CNT_W'(LIST_DEPTH)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(idle_i && pass_start_i)) |=> ovf_o);

  // R2
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && pass_start_i) |=> (!ovf_o && tri_ready_o));
endmodule

bind tile_binner tile_binner_chk #(
  .NUM_TILES(NUM_TILES), .LIST_DEPTH(LIST_DEPTH), .TILE_W(TILE_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pass_start_i(pass_start_i), .idle_i(idle_w),
  .tri_ready_o(tri_ready_o), .out_valid_o(out_valid_o), .out_eot_o(out_eot_o),
  .out_tile_o(out_tile_o), .out_count_o(out_count_o), .ovf_o(ovf_o)
);

// File: tb/tile_binner_tb_top.sv
module tile_binner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 128, SH = 64, TX = 8, NT = 32, D = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       pass_start_i = 0, pass_end_i = 0, tri_valid_i = 0;
  logic       tri_ready_o;
  logic [7:0] tri_idx_i = '0;
  logic [9:0] tri_x0_i = '0, tri_y0_i = '0, tri_x1_i = '0, tri_y1_i = '0;
  logic       out_valid_o, out_eot_o, out_tile_ovf_o, ovf_o;
  logic [4:0] out_tile_o;
  logic [7:0] out_idx_o;
  logic [2:0] out_count_o;

  int n_chk = 0, n_err = 0;
  int exp_cnt [NT];
  int exp_list[NT][D];
  bit exp_tovf[NT];
  bit exp_ovf;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tile_binner dut_i (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int t = 0; t < NT; t++) begin exp_cnt[t] = 0; exp_tovf[t] = 0; end
    exp_ovf = 0;
  endfunction

  function automatic void model_add(int idx, int x0, int y0, int x1, int y1);
    int hx, hy;
    if (x0 >= SW || y0 >= SH || x1 < x0 || y1 < y0) return;
    hx = (x1 > SW-1) ? SW-1 : x1;
    hy = (y1 > SH-1) ? SH-1 : y1;
    for (int r = y0/16; r <= hy/16; r++)
      for (int c = x0/16; c <= hx/16; c++) begin
        int t = r*TX + c;
        if (exp_cnt[t] < D) begin exp_list[t][exp_cnt[t]] = idx; exp_cnt[t]++; end
        else begin exp_tovf[t] = 1; exp_ovf = 1; end
      end
  endfunction

  task automatic start_pass();
    @(negedge clk_i) pass_start_i = 1;
    @(negedge clk_i) pass_start_i = 0;
    model_clear();
    check("R2 ready after start", int'(tri_ready_o), 1);
    check("R2 ovf cleared", int'(ovf_o), 0);
  endtask

  task automatic send_tri(int idx, int x0, int y0, int x1, int y1, bit with_end);
    @(negedge clk_i);
    tri_valid_i = 1; tri_idx_i = 8'(idx);
    tri_x0_i = 10'(x0); tri_y0_i = 10'(y0); tri_x1_i = 10'(x1); tri_y1_i = 10'(y1);
    while (!tri_ready_o) @(negedge clk_i);
    if (with_end) pass_end_i = 1;
    @(posedge clk_i);
    @(negedge clk_i) tri_valid_i = 0; pass_end_i = 0;
    model_add(idx, x0, y0, x1, y1);
  endtask

  task automatic end_pass();
    @(negedge clk_i) pass_end_i = 1;
    @(negedge clk_i) pass_end_i = 0;
    check("R8 ready low after end", int'(tri_ready_o), 0);
  endtask

  // pokes pass_start_i on beat number poke (R9)
  task automatic read_check(int poke);
    int wait_n = 0, beat = 0;
    while (!out_valid_o && wait_n < 1000) begin @(negedge clk_i); wait_n++; end
    check("R8 readout began", int'(out_valid_o), 1);
    for (int t = 0; t < NT; t++) begin
      for (int k = 0; k <= exp_cnt[t]; k++) begin
        pass_start_i = (beat == poke);
        check("R7 valid", int'(out_valid_o), 1);
        check("R7 tile order", int'(out_tile_o), t);
        if (k < exp_cnt[t]) begin
          check("R7 index beat", int'(out_eot_o), 0);
          check("R3 R5 R9 index", int'(out_idx_o), exp_list[t][k]);
        end else begin
          check("R7 marker", int'(out_eot_o), 1);
          check("R3 R4 R6 count", int'(out_count_o), exp_cnt[t]);
          check("R6 tile ovf", int'(out_tile_ovf_o), int'(exp_tovf[t]));
        end
        beat++;
        @(negedge clk_i);
      end
    end
    pass_start_i = 0;
    check("R7 valid falls", int'(out_valid_o), 0);
    check("R10 ovf after readout", int'(ovf_o), int'(exp_ovf));
    check("R8 ready low when idle", int'(tri_ready_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    check("R1 ready", int'(tri_ready_o), 0);
    check("R1 valid", int'(out_valid_o), 0);
    check("R1 ovf", int'(ovf_o), 0);

    // pass 1: directed
    start_pass();
    send_tri(1, 0, 0, 15, 15, 0);
    send_tri(2, 10, 10, 40, 20, 0);
    send_tri(3, 130, 5, 140, 8, 0);     // R4 off right
    send_tri(4, 50, 5, 20, 8, 0);       // R4 inverted
    send_tri(5, 120, 50, 300, 900, 0);  // R3 clamp
    send_tri(6, 0, 0, 3, 3, 0);
    @(negedge clk_i) pass_start_i = 1;  // R9 during binning
    @(negedge clk_i) pass_start_i = 0;
    send_tri(7, 0, 0, 3, 3, 0);
    send_tri(8, 0, 0, 3, 3, 0);         // R6 drop
    send_tri(9, 0, 0, 3, 3, 0);
    send_tri(10, 16, 0, 16, 0, 1);      // R8 same-cycle end
    read_check(5);
    @(negedge clk_i);
    check("R10 ovf held in idle", int'(ovf_o), 1);

    // pass 2: random
    start_pass();
    for (int i = 0; i < 40; i++) begin
      int x0 = $urandom % 150, y0 = $urandom % 80;
      send_tri(i + 20, x0, y0, x0 + $urandom % 40, y0 + $urandom % 24, i == 39);
    end
    read_check(-1);

    // pass 3: empty
    start_pass();
    end_pass();
    read_check(3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule